// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block reads bytes from an 8-bit asynchronous NAND flash device. The requester gives it a single-cycle start pulse, a 32-bit flat byte address and a byte count. The block cuts the flat address into a column inside the page, a page inside the block, a block number and a plane bit.

It then drives the device bus through a fixed sequence. First it sends the read-setup command, then five address cycles, then the read-confirm command. After that it lets the data bus go idle and waits on the device's ready/busy line. Finally it pulses the read strobe once per byte and hands each byte downstream over a valid/ready interface.

Every write or read strobe on the device bus is built from three phases, each counted in system clocks: a setup phase, an active-low strobe phase and a hold phase. One more phase, a release gap, turns the data bus around after the last command. A further short guard delay runs before ready/busy is first looked at. All of these counts are parameters. Requests that would run past the end of the 8192-byte page are cut off at the page end and flagged.

Top module: `nand_rd_seq`

## Requirements
- R1: An accepted request produces exactly seven bus write cycles. They are: command 0x00 with `nand_cle` high and `nand_ale` low, then five address bytes with `nand_ale` high and `nand_cle` low, then command 0x30 with `nand_cle` high. `nand_cle` and `nand_ale` are never high together, and one of them is high whenever `nand_we_n` rises.
- R2: The flat address is read as column = bits 12:0, page = bits 20:13, block = bits 30:21 and plane = bit 31. The five address bytes are sent in this order:
  1. column[7:0]
  2. {3'b000, column[12:8]}
  3. page
  4. {block[6:0], plane}
  5. {5'b00000, block[9:7]}
- R3: `nand_we_n` and `nand_re_n` are low for exactly STROBE_CLKS clocks per pulse (default 2). Each pulse is preceded by SETUP_CLKS clocks (default 1) and followed by HOLD_CLKS clocks (default 10). The two strobes are never low together.
- R4: After the 0x30 command's hold phase, the block waits TURN_CLKS plus TWB_CLKS clocks (defaults 1 and 2) before it first samples `nand_rb`. No `nand_re_n` pulse starts while `nand_rb` is low.
- R5: Data bytes come out in ascending column order, starting at the requested column. Each byte is the value on `nand_dq_in` in the last clock before `nand_re_n` rises. The number of bytes delivered and the number of read pulses both equal the granted length.
- R6: A byte leaves the output only in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. No new `nand_re_n` pulse starts while a byte is still waiting.
- R7: If column + count is greater than 8192, only 8192 − column bytes are read and `range_err` is set. An exact fit up to the page end is not an error. `range_err` keeps its value until the next accepted request.
- R8: `busy` rises in the cycle after an accepted start and stays high until the final byte has been taken. Start pulses while `busy` is high are ignored, and so is a start with a count of zero.
- R9: `nand_ce_n` is low from the first command cycle until the final read pulse has completed, and high while idle.
- R10: After reset: `busy`, `out_valid`, `range_err`, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, and `nand_ce_n`, `nand_we_n` and `nand_re_n` are high.
- R11: `nand_dq_oe` is high only during the command/address write cycles, and is never high while `nand_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| lin_addr | input | 32 | Flat byte address |
| byte_cnt | input | 14 | Number of bytes requested (0 ignored) |
| busy | output | 1 | Request in progress |
| range_err | output | 1 | Last request was cut at the page end |
| out_data | output | 8 | Byte to consumer |
| out_valid | output | 1 | `out_data` holds a byte |
| out_ready | input | 1 | Consumer accepts the byte |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus value driven during write cycles |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The address decode is tried with three kinds of address:
- A mixed-bit address, which shows that each field lands in the right address byte.
- An address with the plane bit set and all block bits set, which shows the plane packed under the block and the upper block bits in the fifth byte.
- Addresses near the page end, which separate an exact fit from an overrun that must be cut and flagged.

The bench's device model returns a byte pattern that depends on the column, so data offset by one column is caught. The data path is run with the consumer always ready and with a stalling consumer; the stalling case shows that read pulses pause and that held bytes stay put. Separate requests check the ready/busy wait, a start while busy and a zero count.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam int COL_W       = 13;
    localparam int PAGE_W      = 8;
    localparam int BLK_W       = 10;
    localparam int PAGE_BYTES  = 1 << COL_W;
    localparam int ADDR_CYCLES = 5;
    localparam int SEQ_LEN     = ADDR_CYCLES + 2;

    localparam logic [7:0] CMD_SETUP   = 8'h00;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;

    // Field layout of the flat address, most significant first.
    typedef struct packed {
        logic              plane;
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
    } nand_loc_t;

    // One write cycle on the device bus.
    typedef struct packed {
        logic [7:0] data;
        logic       cle;
        logic       ale;
    } bus_cycle_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_HOLD} phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_TURN, S_TWB, S_WRDY, S_READ, S_DRAIN
    } seq_e;

    // Byte n (0..4) of the address phase.
    function automatic logic [7:0] addr_cycle(input nand_loc_t loc, input int unsigned n);
        logic [7:0] b;
        b = '0;
        case (n)
            0:       b = loc.col[7:0];
            1:       b = {3'b000, loc.col[12:8]};
            2:       b = loc.page;
            3:       b = {loc.blk[6:0], loc.plane};
            default: b = {5'b00000, loc.blk[9:7]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_rd_pkg::*;
#(
    parameter int SETUP_CLKS = 1,
    parameter int ACT_CLKS   = 2,
    parameter int HOLD_CLKS  = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    output phase_e phase,
    output logic   sample,
    output logic   done
);

    localparam int MAX_A = (SETUP_CLKS > ACT_CLKS) ? SETUP_CLKS : ACT_CLKS;
    localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (go) begin
                    ph_q  <= PH_SETUP;
                    cnt_q <= CW'(SETUP_CLKS - 1);
                end
                PH_SETUP: if (cnt_q == '0) begin
                    ph_q  <= PH_ACT;
                    cnt_q <= CW'(ACT_CLKS - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_ACT: if (cnt_q == '0) begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= CW'(HOLD_CLKS - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: if (cnt_q == '0) begin
                    ph_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign phase  = ph_q;
    assign sample = (ph_q == PH_ACT)  && (cnt_q == '0);
    assign done   = (ph_q == PH_HOLD) && (cnt_q == '0);

endmodule

// File: rtl/nand_addr_map.sv
module nand_addr_map
    import nand_rd_pkg::*;
(
    input  nand_loc_t  loc,
    input  logic [2:0] seq_idx,
    output bus_cycle_t cyc
);

    bus_cycle_t cyc_tab [SEQ_LEN];

    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_cyc
        if (g == 0) begin : g_first
            assign cyc_tab[g] = '{data: CMD_SETUP, cle: 1'b1, ale: 1'b0};
        end else if (g == SEQ_LEN - 1) begin : g_last
            assign cyc_tab[g] = '{data: CMD_CONFIRM, cle: 1'b1, ale: 1'b0};
        end else begin : g_addr
            assign cyc_tab[g] = '{data: addr_cycle(loc, g - 1), cle: 1'b0, ale: 1'b1};
        end
    end

    always_comb begin
        cyc = '0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            if (seq_idx == 3'(i)) cyc = cyc_tab[i];
        end
    end

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nand_rd_pkg::*;
#(
    parameter int SETUP_CLKS  = 1,
    parameter int STROBE_CLKS = 2,
    parameter int HOLD_CLKS   = 10,
    parameter int TURN_CLKS   = 1,
    parameter int TWB_CLKS    = 2,
    parameter int LEN_W       = COL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      lin_addr,
    input  logic [LEN_W-1:0] byte_cnt,
    output logic             busy,
    output logic             range_err,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);

    localparam int WAIT_MAX = (TURN_CLKS > TWB_CLKS) ? TURN_CLKS : TWB_CLKS;
    localparam int WW       = (WAIT_MAX < 2) ? 1 : $clog2(WAIT_MAX);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);
    localparam logic [2:0]       LAST_IDX = 3'(SEQ_LEN - 1);

    seq_e             state_q;
    nand_loc_t        loc_q;
    logic [2:0]       idx_q;
    logic [LEN_W-1:0] remain_q;
    logic [WW-1:0]    wait_q;
    logic             err_q;
    logic [7:0]       data_q;
    logic             valid_q;

    phase_e     phase;
    logic       tmr_go, tmr_sample, tmr_done;
    bus_cycle_t cyc;

    nand_loc_t        req_loc;
    logic [LEN_W-1:0] room, grant_len;
    logic             over, accept, in_issue;

    // Request decode and page-end clipping
    assign req_loc   = nand_loc_t'(lin_addr);
    assign room      = PAGE_LEN - LEN_W'(req_loc.col);
    assign over      = byte_cnt > room;
    assign grant_len = over ? room : byte_cnt;
    assign accept    = (state_q == S_IDLE) && start && (byte_cnt != '0);

    assign in_issue = (state_q == S_ISSUE);
    assign tmr_go   = (phase == PH_IDLE) &&
                      (in_issue || ((state_q == S_READ) && !valid_q));

    nand_phase_timer #(
        .SETUP_CLKS (SETUP_CLKS),
        .ACT_CLKS   (STROBE_CLKS),
        .HOLD_CLKS  (HOLD_CLKS)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .go     (tmr_go),
        .phase  (phase),
        .sample (tmr_sample),
        .done   (tmr_done)
    );

    nand_addr_map u_map (
        .loc     (loc_q),
        .seq_idx (idx_q),
        .cyc     (cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            loc_q    <= '0;
            idx_q    <= '0;
            remain_q <= '0;
            wait_q   <= '0;
            err_q    <= 1'b0;
            data_q   <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (valid_q && out_ready) valid_q <= 1'b0;
            case (state_q)
                S_IDLE: if (accept) begin
                    state_q  <= S_ISSUE;
                    loc_q    <= req_loc;
                    idx_q    <= '0;
                    remain_q <= grant_len;
                    err_q    <= over;
                end
                S_ISSUE: if (tmr_done) begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= S_TURN;
                        wait_q  <= WW'(TURN_CLKS - 1);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_TURN: if (wait_q == '0) begin
                    state_q <= S_TWB;
                    wait_q  <= WW'(TWB_CLKS - 1);
                end else begin
                    wait_q <= wait_q - 1'b1;
                end
                S_TWB: if (wait_q == '0) begin
                    state_q <= S_WRDY;
                end else begin
                    wait_q <= wait_q - 1'b1;
                end
                S_WRDY: if (nand_rb) state_q <= S_READ;
                S_READ: begin
                    if (tmr_sample) begin
                        data_q  <= nand_dq_in;
                        valid_q <= 1'b1;
                    end
                    if (tmr_done) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == LEN_W'(1)) state_q <= S_DRAIN;
                    end
                end
                S_DRAIN: if (!valid_q || out_ready) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != S_IDLE);
    assign range_err   = err_q;
    assign out_data    = data_q;
    assign out_valid   = valid_q;
    assign nand_ce_n   = (state_q == S_IDLE) || (state_q == S_DRAIN);
    assign nand_cle    = in_issue && cyc.cle;
    assign nand_ale    = in_issue && cyc.ale;
    assign nand_we_n   = !(in_issue && (phase == PH_ACT));
    assign nand_re_n   = !((state_q == S_READ) && (phase == PH_ACT));
    assign nand_dq_out = in_issue ? cyc.data : 8'h00;
    assign nand_dq_oe  = in_issue;

endmodule

// File: rtl/nand_rd_seq_sva.sv
module nand_rd_seq_sva #(
    parameter int STROBE_CLKS = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe
);

    logic [7:0] we_low, re_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low <= '0;
            re_low <= '0;
        end else begin
            we_low <= nand_we_n ? 8'd0 : we_low + 8'd1;
            re_low <= nand_re_n ? 8'd0 : re_low + 8'd1;
        end
    end

    a_r1_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    a_r1_latch_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (nand_cle || nand_ale));

    a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (we_low == 8'(STROBE_CLKS)));

    a_r3_re_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_re_n) |-> (re_low == 8'(STROBE_CLKS)));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    a_r6_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r6_no_read_pending: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_re_n) |-> !out_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nand_ce_n && !out_valid));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && out_valid && !out_ready) |=> busy);

    a_r9_ce_covers: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

endmodule

bind nand_rd_seq nand_rd_seq_sva #(.STROBE_CLKS(STROBE_CLKS)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_rd_seq_test.sv
module nand_rd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] lin_addr = '0;
    logic [13:0] byte_cnt = '0;
    logic        busy, range_err, out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb;

    always #10 clk = ~clk;

    nand_rd_seq uut (
        .clk(clk), .rst(rst), .start(start), .lin_addr(lin_addr), .byte_cnt(byte_cnt),
        .busy(busy), .range_err(range_err), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb)
    );

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device model
    function automatic logic [7:0] pat(input logic [7:0] pg, input logic [9:0] bk,
                                       input logic pl, input logic [12:0] c);
        return (c[7:0] ^ (8'(c[12:8]) * 8'd37) ^ pg ^ bk[9:2]) + {pl, 7'h11};
    endfunction

    logic [7:0] lat_b [16];
    logic       lat_c [16];
    int         lat_n = 0;
    logic [12:0] m_col = '0;
    logic [7:0]  m_page = '0;
    logic [9:0]  m_blk = '0;
    logic        m_plane = 1'b0;
    int busy_left = 0, rb_busy_len = 30;
    int re_falls = 0, rb_viol = 0;

    assign nand_rb    = (busy_left == 0);
    assign nand_dq_in = pat(m_page, m_blk, m_plane, m_col);

    always @(posedge nand_we_n) begin
        if (!nand_ce_n && (nand_cle || nand_ale) && lat_n < 16) begin
            lat_b[lat_n] = nand_dq_out;
            lat_c[lat_n] = nand_cle;
            lat_n++;
            if (nand_cle && nand_dq_out == 8'h30 && lat_n >= 6) begin
                m_col     = {lat_b[lat_n-5][4:0], lat_b[lat_n-6]};
                m_page    = lat_b[lat_n-4];
                m_plane   = lat_b[lat_n-3][0];
                m_blk     = {lat_b[lat_n-2][2:0], lat_b[lat_n-3][7:1]};
                busy_left = rb_busy_len;
            end
        end
    end

    always @(posedge clk) if (busy_left > 0) busy_left--;
    always @(negedge nand_re_n) begin
        re_falls++;
        if (!nand_rb) rb_viol++;
    end
    always @(posedge nand_re_n) m_col++;

    // Consumer and monitors
    logic [7:0] got [64];
    int got_n = 0, busy_low_xfer = 0, stall_bad = 0;
    int rdy_mode = 0, rcnt = 0;
    int we_run = 0, re_run = 0, width_bad = 0, oe_bad = 0;
    bit stalled = 1'b0;
    logic [7:0] stall_data = '0;

    always @(posedge clk) begin
        if (!rst) begin
            if (stalled && (!out_valid || out_data != stall_data)) stall_bad++;
            stalled    = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                if (got_n < 64) got[got_n] = out_data;
                got_n++;
                if (!busy) busy_low_xfer++;
            end
        end
    end

    always @(negedge clk) begin
        rcnt++;
        out_ready <= (rdy_mode == 0) ? 1'b1 : (rcnt % 3 == 0);
    end

    always @(negedge clk) begin
        if (!nand_we_n) we_run++;
        else begin
            if (we_run != 0 && we_run != 2) width_bad++;
            we_run = 0;
        end
        if (!nand_re_n) re_run++;
        else begin
            if (re_run != 0 && re_run != 2) width_bad++;
            re_run = 0;
        end
        if (!rst && !nand_re_n && nand_dq_oe) oe_bad++;
    end

    // Helpers
    function automatic logic [7:0] exp_cycle(input logic [31:0] a, input int i);
        case (i)
            0:       return 8'h00;
            1:       return a[7:0];
            2:       return {3'b000, a[12:8]};
            3:       return a[20:13];
            4:       return {a[27:21], a[31]};
            5:       return {5'b00000, a[30:28]};
            default: return 8'h30;
        endcase
    endfunction

    task automatic clear_logs();
        lat_n = 0; got_n = 0; re_falls = 0; rb_viol = 0;
        width_bad = 0; busy_low_xfer = 0; stall_bad = 0; oe_bad = 0;
    endtask

    task automatic launch(input logic [31:0] a, input logic [13:0] n);
        @(negedge clk);
        lin_addr = a; byte_cnt = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while ((busy || out_valid) && k < 20000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 20000) chk(1'b0, "R8 completion timeout", k, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_seq(input logic [31:0] a);
        chk(lat_n == 7, "R1 write cycle count", lat_n, 7);
        for (int i = 0; i < 7 && i < lat_n; i++) begin
            chk(lat_b[i] == exp_cycle(a, i), "R2 cycle byte", lat_b[i], exp_cycle(a, i));
            chk(lat_c[i] == (i == 0 || i == 6), "R1 cle/ale kind", lat_c[i], (i == 0 || i == 6));
        end
    endtask

    task automatic check_data(input logic [31:0] a, input int n);
        chk(got_n == n, "R5 byte count", got_n, n);
        chk(re_falls == n, "R5 read pulse count", re_falls, n);
        for (int i = 0; i < n && i < got_n; i++) begin
            chk(got[i] == pat(a[20:13], a[30:21], a[31], a[12:0] + 13'(i)),
                "R5 data byte", got[i], pat(a[20:13], a[30:21], a[31], a[12:0] + 13'(i)));
        end
        chk(width_bad == 0, "R3 strobe width", width_bad, 0);
        chk(rb_viol == 0, "R4 read while busy", rb_viol, 0);
        chk(stall_bad == 0, "R6 held byte changed", stall_bad, 0);
        chk(oe_bad == 0, "R11 bus driven during read", oe_bad, 0);
        chk(busy_low_xfer == 0, "R8 busy low at transfer", busy_low_xfer, 0);
        chk(nand_ce_n == 1'b1, "R9 ce released", nand_ce_n, 1);
    endtask

    // Scenarios
    task automatic t_reset();
        chk(busy == 0 && out_valid == 0 && range_err == 0, "R10 status after reset",
            {busy, out_valid, range_err}, 0);
        chk(nand_ce_n && nand_we_n && nand_re_n, "R10 strobes high",
            {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R10 latches low",
            {nand_cle, nand_ale, nand_dq_oe}, 0);
    endtask

    task automatic t_basic();
        logic [31:0] a = {1'b0, 10'h155, 8'hA3, 13'h0123};
        clear_logs(); rdy_mode = 0; rb_busy_len = 30;
        launch(a, 14'd4);
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        chk(nand_ce_n == 1'b0, "R9 ce low from first command", nand_ce_n, 0);
        wait_idle();
        check_seq(a);
        check_data(a, 4);
        chk(range_err == 0, "R7 no error in page", range_err, 0);
    endtask

    task automatic t_plane_stall();
        logic [31:0] a = {1'b1, 10'h3FF, 8'h00, 13'h1F00};
        clear_logs(); rdy_mode = 1; rb_busy_len = 80;
        launch(a, 14'd6);
        wait_idle();
        check_seq(a);
        check_data(a, 6);
        rdy_mode = 0;
    endtask

    task automatic t_overrun();
        logic [31:0] a = {1'b0, 10'h0A2, 8'h7F, 13'h1FFE};
        clear_logs(); rb_busy_len = 10;
        launch(a, 14'd5);
        wait_idle();
        check_data(a, 2);
        chk(range_err == 1'b1, "R7 overrun flagged", range_err, 1);
    endtask

    task automatic t_exact_fit();
        logic [31:0] a = {1'b0, 10'h201, 8'h05, 13'h1FFC};
        clear_logs(); rb_busy_len = 5;
        launch(a, 14'd4);
        wait_idle();
        check_data(a, 4);
        chk(range_err == 1'b0, "R7 exact fit not flagged", range_err, 0);
    endtask

    task automatic t_ignore_busy();
        logic [31:0] a = {1'b0, 10'h011, 8'h22, 13'h0040};
        logic [31:0] b = {1'b1, 10'h3C0, 8'hEE, 13'h0800};
        clear_logs(); rb_busy_len = 20;
        launch(a, 14'd3);
        repeat (30) @(negedge clk);
        launch(b, 14'd5);
        wait_idle();
        check_seq(a);
        chk(got_n == 3, "R8 second start ignored", got_n, 3);
    endtask

    task automatic t_zero();
        clear_logs();
        launch({1'b0, 10'h001, 8'h01, 13'h0001}, 14'd0);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R8 zero count ignored", busy, 0);
        chk(lat_n == 0, "R8 zero count no bus cycles", lat_n, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_plane_stall();
        t_overrun();
        t_exact_fit();
        t_ignore_busy();
        t_zero();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

endmodule